// File: doc/BRIEF.md
# GPIO event detect unit

This block watches a vector of general-purpose input pins and records events on them for an interrupt controller. Every pin is brought into the clock domain through a synchronizer. Six independent per-pin enable registers select what counts as an event: a rising or falling edge of the synchronized sample, a high or low level of that sample, or a rising or falling edge seen on the first synchronizer stage. The first-stage edges reach the status register one clock earlier than the synchronized ones. Any enabled condition sets a sticky per-pin status bit. Software clears a status bit by writing a one to it.

The status vector is reduced to three interrupt lines, each covering a fixed, contiguous range of pins. The middle range straddles the boundary between the two 32-bit register words. All registers sit on a simple word-wide register bus. Reads are combinational from the current address. A write takes effect at the clock edge on which it is presented.

Top module: `gpio_event_unit`

## Requirements
- R1: After reset every enable register and every status bit is 0 and all three interrupt lines are low.
- R2: Register words sit at byte address base + 4*bank, with bank 0 holding pins 0..31 and bank 1 holding pins 32..53 in bits 0..21. The bases are: status 0x40, synchronous rising enable 0x4C, synchronous falling enable 0x58, high-level enable 0x64, low-level enable 0x70, first-stage rising enable 0x7C, first-stage falling enable 0x88. Enable words read back as written, bank-1 bits 22..31 read 0, and unmapped addresses read 0.
- R3: With its synchronous rising (falling) enable set, a pin that goes high (low) sets its status bit three clocks after the pin changes, once the two-stage synchronized sample differs from the sample before it. With both enables set, both directions are detected.
- R4: With its high (low) level enable set, a pin sets its status bit on every clock while its synchronized sample is high (low), so a clear write cannot remove the bit while the level persists.
- R5: With its first-stage rising (falling) enable set, a pin change sets its status bit two clocks after the change, one clock earlier than the synchronous edge enable.
- R6: Writing a word to a status address clears exactly the bits written as 1; bits written as 0 keep their value.
- R7: When a clear write and a new event hit the same status bit at the same clock edge, the bit ends up set.
- R8: A set status bit stays set after all its enables are cleared, until a clear write removes it.
- R9: Line 0 is high when any status bit of pins 0..27 is set, line 1 for pins 28..45, line 2 for pins 46..53.
- R10: A pin with no enable set never sets its status bit, whatever its input does.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS (54) | Raw pin inputs, asynchronous to the clock |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, applied at the next clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address, combinational |
| irq_o | output | 3 | Interrupt lines for the three pin ranges |

## Verification
A software clear write and a newly detected event can land on the same status bit at the same clock edge. The bench provokes this by leaving a status bit set, raising the pin, and timing the clear write to arrive on the exact edge where the synchronous rising detector fires. The bit must still read as set afterwards, and a second clear write with no event must then remove it. A persisting level gives the same collision on every clock, and the bench checks that a clear write does not remove the bit in that case either.

// File: rtl/gev_pkg.sv
package gev_pkg;

    // register bus
    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;

    // detection kinds that own an enable register, in address order
    localparam int unsigned NUM_KINDS = 6;
    localparam int unsigned K_RISE    = 0;
    localparam int unsigned K_FALL    = 1;
    localparam int unsigned K_HIGH    = 2;
    localparam int unsigned K_LOW     = 3;
    localparam int unsigned K_ARISE   = 4;
    localparam int unsigned K_AFALL   = 5;

    // address layout: status block first, then one block per kind
    localparam int unsigned STAT_BASE   = 'h40;
    localparam int unsigned KIND_STRIDE = 12;

    localparam int unsigned NUM_LINES = 3;

    function automatic int unsigned bank_count(input int unsigned pins);
        return (pins + BUS_DW - 1) / BUS_DW;
    endfunction

    function automatic int unsigned bank_bits(input int unsigned banks);
        return (banks > 1) ? $clog2(banks) : 1;
    endfunction

endpackage

// File: rtl/gev_sync.sv
module gev_sync #(
    parameter int unsigned WIDTH  = 54,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] first_o,
    output logic [WIDTH-1:0] first_prev_o,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] sync_prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // the first stage's previous value is held by the second stage
    assign first_o      = s_q.chain[0];
    assign first_prev_o = s_q.chain[1];
    assign sync_o       = s_q.chain[STAGES-1];
    assign sync_prev_o  = s_q.prev;

endmodule

// File: rtl/gev_detect.sv
module gev_detect
    import gev_pkg::*;
#(
    parameter int unsigned WIDTH = 54
) (
    input  logic [WIDTH-1:0]                first_i,
    input  logic [WIDTH-1:0]                first_prev_i,
    input  logic [WIDTH-1:0]                sync_i,
    input  logic [WIDTH-1:0]                sync_prev_i,
    input  logic [NUM_KINDS-1:0][WIDTH-1:0] en_i,
    output logic [WIDTH-1:0]                hit_o
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic rise_s, fall_s, rise_f, fall_f;

        assign rise_s = sync_i[p] & ~sync_prev_i[p];
        assign fall_s = ~sync_i[p] & sync_prev_i[p];
        assign rise_f = first_i[p] & ~first_prev_i[p];
        assign fall_f = ~first_i[p] & first_prev_i[p];

        assign hit_o[p] = (en_i[K_RISE][p]  & rise_s)
                        | (en_i[K_FALL][p]  & fall_s)
                        | (en_i[K_HIGH][p]  & sync_i[p])
                        | (en_i[K_LOW][p]   & ~sync_i[p])
                        | (en_i[K_ARISE][p] & rise_f)
                        | (en_i[K_AFALL][p] & fall_f);
    end

endmodule

// File: rtl/gev_decode.sv
module gev_decode
    import gev_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_W    = 1
) (
    input  logic [BUS_AW-1:0] addr_i,
    output logic              hit_o,
    output logic              is_stat_o,
    output logic [2:0]        kind_o,
    output logic [BANK_W-1:0] bank_o
);

    always_comb begin
        hit_o     = 1'b0;
        is_stat_o = 1'b0;
        kind_o    = '0;
        bank_o    = '0;
        // block 0 is status, blocks 1..NUM_KINDS are enables
        for (int k = 0; k <= NUM_KINDS; k++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (addr_i == BUS_AW'(STAT_BASE + k * KIND_STRIDE + b * 4)) begin
                    hit_o     = 1'b1;
                    is_stat_o = (k == 0);
                    kind_o    = (k == 0) ? 3'd0 : 3'(k - 1);
                    bank_o    = BANK_W'(b);
                end
            end
        end
    end

endmodule

// File: rtl/gev_irq_group.sv
module gev_irq_group #(
    parameter int unsigned LO = 0,
    parameter int unsigned HI = 27
) (
    input  logic [HI-LO:0] slice_i,
    output logic           line_o
);

    assign line_o = |slice_i;

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
    import gev_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 54,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LINE1_FIRST = 28,
    parameter int unsigned LINE2_FIRST = 46
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PINS-1:0]  pins_i,
    input  logic [BUS_AW-1:0]    bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic [BUS_DW-1:0]    bus_wdata_i,
    output logic [BUS_DW-1:0]    bus_rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);

    localparam int unsigned NUM_BANKS = bank_count(NUM_PINS);
    localparam int unsigned BANK_W    = bank_bits(NUM_BANKS);
    localparam int unsigned PAD_W     = NUM_BANKS * BUS_DW;
    localparam logic [PAD_W-1:0] PIN_MASK = PAD_W'({NUM_PINS{1'b1}});
    localparam int unsigned BOUND [NUM_LINES+1] = '{0, LINE1_FIRST, LINE2_FIRST, NUM_PINS};

    typedef struct packed {
        logic [NUM_KINDS-1:0][PAD_W-1:0] en;
        logic [PAD_W-1:0]                stat;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [NUM_PINS-1:0] first_w, first_prev_w, sync_w, sync_prev_w;
    logic [NUM_PINS-1:0] hit_w;
    logic [NUM_PINS-1:0] stat_w;
    logic [NUM_PINS-1:0] en_any_w;
    logic [NUM_KINDS-1:0][NUM_PINS-1:0] en_pins;
    logic [PAD_W-1:0]    hit_pad;
    logic [PAD_W-1:0]    clr_mask;
    logic [PAD_W-1:0]    rd_vec;

    logic              dec_hit;
    logic              dec_stat;
    logic [2:0]        dec_kind;
    logic [BANK_W-1:0] dec_bank;

    gev_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .raw_i        (pins_i),
        .first_o      (first_w),
        .first_prev_o (first_prev_w),
        .sync_o       (sync_w),
        .sync_prev_o  (sync_prev_w)
    );

    always_comb begin
        en_any_w = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            en_pins[k] = st_q.en[k][NUM_PINS-1:0];
            en_any_w   = en_any_w | en_pins[k];
        end
    end

    gev_detect #(
        .WIDTH (NUM_PINS)
    ) u_detect (
        .first_i      (first_w),
        .first_prev_i (first_prev_w),
        .sync_i       (sync_w),
        .sync_prev_i  (sync_prev_w),
        .en_i         (en_pins),
        .hit_o        (hit_w)
    );

    gev_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_decode (
        .addr_i    (bus_addr_i),
        .hit_o     (dec_hit),
        .is_stat_o (dec_stat),
        .kind_o    (dec_kind),
        .bank_o    (dec_bank)
    );

    assign hit_pad = PAD_W'(hit_w);

    // next-state: enable writes replace a word, status writes clear ones,
    // a fresh event is ORed in after the clear so it wins a collision
    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (bus_wr_i && dec_hit) begin
            if (dec_stat) begin
                clr_mask[int'(dec_bank) * BUS_DW +: BUS_DW] = bus_wdata_i;
            end else begin
                st_d.en[dec_kind][int'(dec_bank) * BUS_DW +: BUS_DW] = bus_wdata_i;
            end
        end
        for (int k = 0; k < NUM_KINDS; k++) begin
            st_d.en[k] = st_d.en[k] & PIN_MASK;
        end
        st_d.stat = ((st_q.stat & ~clr_mask) | hit_pad) & PIN_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_vec      = dec_stat ? st_q.stat : st_q.en[dec_kind];
        bus_rdata_o = dec_hit ? rd_vec[int'(dec_bank) * BUS_DW +: BUS_DW] : '0;
    end

    assign stat_w = st_q.stat[NUM_PINS-1:0];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        gev_irq_group #(
            .LO (BOUND[g]),
            .HI (BOUND[g+1] - 1)
        ) u_group (
            .slice_i (stat_w[BOUND[g+1]-1:BOUND[g]]),
            .line_o  (irq_o[g])
        );
    end

endmodule

// File: rtl/gpio_event_unit_chk.sv
module gpio_event_unit_chk
    import gev_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 54,
    parameter int unsigned LINE1_FIRST = 28,
    parameter int unsigned LINE2_FIRST = 46
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [BUS_AW-1:0]    bus_addr_i,
    input logic                 bus_wr_i,
    input logic [BUS_DW-1:0]    bus_wdata_i,
    input logic [NUM_PINS-1:0]  hit_i,
    input logic [NUM_PINS-1:0]  stat_i,
    input logic [NUM_PINS-1:0]  en_any_i,
    input logic [NUM_LINES-1:0] irq_i
);

    logic [NUM_PINS-1:0]  clr;
    logic [NUM_LINES-1:0] irq_exp;

    // clear request seen at the bus, independent of the decoder
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            clr[p] = bus_wr_i
                   && (bus_addr_i == BUS_AW'(STAT_BASE + 4 * (p / BUS_DW)))
                   && bus_wdata_i[p % BUS_DW];
        end
    end

    always_comb begin
        irq_exp = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (p < LINE1_FIRST)      irq_exp[0] = irq_exp[0] | stat_i[p];
            else if (p < LINE2_FIRST) irq_exp[1] = irq_exp[1] | stat_i[p];
            else                      irq_exp[2] = irq_exp[2] | stat_i[p];
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (stat_i == '0 && irq_i == '0));

    a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_i & $past(clr & ~hit_i)) == '0));

    a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_i & $past(hit_i)) == $past(hit_i)));

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_i & $past(stat_i & ~clr)) == $past(stat_i & ~clr)));

    a_r9_irq_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i == irq_exp);

    a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i & ~en_any_i) == '0);

endmodule

bind gpio_event_unit gpio_event_unit_chk #(
    .NUM_PINS    (NUM_PINS),
    .LINE1_FIRST (LINE1_FIRST),
    .LINE2_FIRST (LINE2_FIRST)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .hit_i       (hit_w),
    .stat_i      (stat_w),
    .en_any_i    (en_any_w),
    .irq_i       (irq_o)
);

// File: tb/gpio_event_unit_bench.sv
`timescale 1ns/1ps
module gpio_event_unit_bench;

    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins;
    logic [7:0]    addr;
    logic          wr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [2:0]    irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_event_unit u_gpio_event_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pins_i      (pins),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive now, applied at the next rising edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic read_stat(output logic [63:0] s);
        logic [31:0] lo, hi;
        bus_read(8'h40, lo);
        bus_read(8'h44, hi);
        s = {hi, lo};
    endtask

    task automatic clear_all();
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_write(8'h44, 32'hFFFF_FFFF);
    endtask

    function automatic logic [7:0] en_addr(input int kind, input int bank);
        return 8'(8'h4C + kind * 12 + bank * 4);
    endfunction

    function automatic logic [2:0] line_of(input int p);
        if (p < 28) return 3'b001;
        if (p < 46) return 3'b010;
        return 3'b100;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] s;
        string       req;
        rst_n = 1'b0;
        pins  = '0;
        addr  = '0;
        wr    = 1'b0;
        wdata = '0;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state of every register word and the lines
        for (int k = 0; k <= 6; k++) begin
            for (int b = 0; b < 2; b++) begin
                bus_read(8'(8'h40 + k * 12 + b * 4), d);
                check("R1", $sformatf("reset word k%0d b%0d", k, b), 64'(d), 64'h0);
            end
        end
        check("R1", "reset irq", 64'(irq), 64'h0);

        // R2: read-back, bank-1 masking, separation, unmapped
        bus_write(8'h50, 32'hFFFF_FFFF);
        bus_read(8'h50, d);
        check("R2", "rise bank1 readback", 64'(d), 64'h003F_FFFF);
        bus_write(8'h64, 32'hA5A5_A5A5);
        bus_read(8'h64, d);
        check("R2", "high bank0 readback", 64'(d), 64'hA5A5_A5A5);
        bus_write(8'h8C, 32'h0000_1234);
        bus_read(8'h8C, d);
        check("R2", "afall bank1 readback", 64'(d), 64'h0000_1234);
        bus_read(8'h88, d);
        check("R2", "afall bank0 untouched", 64'(d), 64'h0);
        bus_read(8'h00, d);
        check("R2", "unmapped read", 64'(d), 64'h0);
        bus_write(8'h50, 32'h0);
        bus_write(8'h64, 32'h0);
        bus_write(8'h8C, 32'h0);
        tick(4);
        clear_all();

        // R10: all pins toggle with no enables
        pins = '1;
        tick(5);
        pins = '0;
        tick(5);
        read_stat(s);
        check("R10", "toggle without enables", s, 64'h0);

        // sweep: every pin, every detection kind alone
        for (int p = 0; p < NP; p++) begin
            for (int t = 0; t < 6; t++) begin
                logic base;
                logic [63:0] bit_p;
                base  = t[0];
                bit_p = 64'h1 << p;
                req   = (t < 2) ? "R3" : (t < 4) ? "R4" : "R5";
                pins  = {NP{base}};
                tick(4);
                clear_all();
                bus_write(en_addr(t, p / 32), 32'h1 << (p % 32));
                tick(4);
                read_stat(s);
                check("R10", $sformatf("quiet p%0d k%0d", p, t), s, 64'h0);
                pins[p] = ~base;
                tick(4);
                read_stat(s);
                check(req, $sformatf("event p%0d k%0d", p, t), s, bit_p);
                check("R9", $sformatf("line p%0d k%0d", p, t), 64'(irq), 64'(line_of(p)));
                bus_write(en_addr(t, p / 32), 32'h0);
                tick(2);
                read_stat(s);
                check("R8", $sformatf("sticky p%0d k%0d", p, t), s, bit_p);
                clear_all();
                read_stat(s);
                check("R6", $sformatf("cleared p%0d k%0d", p, t), s, 64'h0);
                pins[p] = base;
                tick(4);
                read_stat(s);
                check("R10", $sformatf("disabled p%0d k%0d", p, t), s | 64'(irq), 64'h0);
            end
        end
        pins = '0;
        tick(4);
        clear_all();

        // R3: both edge enables on pin 40 (bank 1 bit 8)
        bus_write(8'h50, 32'h100);
        bus_write(8'h5C, 32'h100);
        pins[40] = 1'b1;
        tick(4);
        read_stat(s);
        check("R3", "both edges rise", s, 64'h1 << 40);
        clear_all();
        pins[40] = 1'b0;
        tick(4);
        read_stat(s);
        check("R3", "both edges fall", s, 64'h1 << 40);
        bus_write(8'h50, 32'h0);
        bus_write(8'h5C, 32'h0);
        clear_all();

        // R5 vs R3 latency: pin 5 synchronous rise, pin 6 first-stage rise
        bus_write(8'h4C, 32'h20);
        bus_write(8'h7C, 32'h40);
        addr = 8'h40;
        @(negedge clk);
        pins[5] = 1'b1;
        pins[6] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R5", "first-stage edge after two clocks", 64'(rdata), 64'h40);
        @(negedge clk);
        #1;
        check("R3", "synchronous edge after three clocks", 64'(rdata), 64'h60);
        bus_write(8'h4C, 32'h0);
        bus_write(8'h7C, 32'h0);
        pins[5] = 1'b0;
        pins[6] = 1'b0;
        tick(4);
        clear_all();

        // R4: level persists through a clear write
        bus_write(8'h64, 32'h400);
        pins[10] = 1'b1;
        tick(4);
        bus_write(8'h40, 32'h400);
        read_stat(s);
        check("R4", "high level survives clear", s, 64'h400);
        pins[10] = 1'b0;
        tick(4);
        bus_write(8'h40, 32'h400);
        read_stat(s);
        check("R4", "level gone then cleared", s, 64'h0);
        bus_write(8'h64, 32'h0);

        // R7: clear write on the edge where a new event fires
        bus_write(8'h4C, 32'h8);
        pins[3] = 1'b1;
        tick(4);
        pins[3] = 1'b0;
        tick(4);
        read_stat(s);
        check("R7", "bit set before collision", s, 64'h8);
        @(negedge clk);
        pins[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_write(8'h40, 32'h8);
        read_stat(s);
        check("R7", "event wins over clear", s, 64'h8);
        bus_write(8'h40, 32'h8);
        read_stat(s);
        check("R7", "plain clear afterwards", s, 64'h0);
        bus_write(8'h4C, 32'h0);
        pins[3] = 1'b0;
        tick(4);

        // R6: only ones clear; zero word leaves bits alone
        bus_write(8'h4C, 32'h4000_0001);
        pins[0]  = 1'b1;
        pins[30] = 1'b1;
        tick(4);
        bus_write(8'h4C, 32'h0);
        bus_write(8'h40, 32'h1);
        read_stat(s);
        check("R6", "partial clear", s, 64'h4000_0000);
        check("R9", "line 1 from pin 30", 64'(irq), 64'h2);
        bus_write(8'h40, 32'h0);
        bus_write(8'h44, 32'h0);
        read_stat(s);
        check("R6", "zero word keeps bit", s, 64'h4000_0000);
        clear_all();
        read_stat(s);
        check("R6", "final clear", s | 64'(irq), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule